// File: doc/BRIEF.md
# Four-Frequency Row-Sum Correlator

This coprocessor correlates a vector of 24 row sums, taken across one rotated orientation of an image window, against sine and cosine waves at four fixed frequencies k = 1, 2, 3 and 4. The angle step is pi/16 per sample. Each frequency has its own lane. A lane forms two sums, sum of row_sum(i)·sin(k·i·pi/16) and sum of row_sum(i)·cos(k·i·pi/16), using coefficients in fixed point scaled by 2^16. Software squares and adds these sums to get a resonance energy. That step is not part of this block.

A processor reaches the block over a 32-bit APB-style bus that decodes two word locations. The command location takes operation codes and reads back a status word. The data location takes the 24 row sums on writes and returns one correlation sum on each read. For one image block, software loads and runs 16 vectors in turn, one per orientation. It reads the eight sums back after each vector.

Top module: `dft_corr_engine`

## Requirements
- R1: After reset the status word reads 0 (idle, no error, no samples held, read pointer 0), and the data location reads 0.
- R2: A write to the data location (offset 0x4) stores pwdata[15:0] as the next row sum, in index order 0 to 23. The held count appears in status bits [12:8]. Once 24 samples are held, further data writes are ignored and the count stays 24.
- R3: Writing code 2 (pwdata[1:0]) to the command location (offset 0x0) with 24 samples held and the block idle starts a run. In the same edge the count and the read pointer clear to 0. Status bit 0 (busy) then reads 1 for exactly 24 cycles.
- R4: A start code is ignored when fewer than 24 samples are held, and also while busy.
- R5: Lane k (k = 1..4) accumulates row_sum(i)·round(65536·sin(k·i·pi/16)) and row_sum(i)·round(65536·cos(k·i·pi/16)) over i = 0..23, in 40-bit signed accumulators.
- R6: A read of the data location returns bits [39:8] of the sum chosen by the read pointer (status bits [18:16]). The order is sin1, cos1, sin2, cos2, sin3, cos3, sin4, cos4. Code 3 advances the pointer, and it wraps from 7 to 0.
- R7: A data write while busy is ignored and sets the sticky error flag (status bit 1). Only code 1 (clear) resets the flag. Clear also zeroes the count, the read pointer and all sums, and it ends any run.
- R8: Every run starts its sums from zero, so results never carry over from an earlier vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 4 | Byte address; 0x0 command/status, 0x4 data |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |

## Verification
The checker watches on every cycle that each run stays busy for exactly 24 cycles. It also watches that a start with the count short of 24 leaves the block idle, that a data write during a run sets the error flag and leaves the count unchanged, that the error flag holds until a clear, and that the count never exceeds 24. The numeric content of the sums can only be shown by the bench's scenarios. These cover the coefficient rounding, the lane-to-frequency mapping, the read-out order and window, the ignored 25th sample, and the restart from zero between vectors. The bench compares them against a model built from real-valued sine and cosine.

// File: rtl/dft_corr_engine.sv
module dft_corr_engine #(
  parameter int N_SAMP    = 24,
  parameter int N_LANE    = 4,
  parameter int SAMP_W    = 16,
  parameter int COEF_W    = 18,
  parameter int ACC_W     = 40,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 4'h0,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 4'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata
);

  localparam int CNT_W = $clog2(N_SAMP + 1);
  localparam int IDX_W = $clog2(N_SAMP);
  localparam int N_RES = 2 * N_LANE;
  localparam int RP_W  = $clog2(N_RES);
  localparam int PH_W  = 5; // 32 phase steps per turn (pi/16 each)

  localparam logic [1:0] OP_CLEAR = 2'd1;
  localparam logic [1:0] OP_START = 2'd2;
  localparam logic [1:0] OP_NEXT  = 2'd3;

  logic              busy, err;
  logic [CNT_W-1:0]  wcount;
  logic [IDX_W-1:0]  idx;
  logic [RP_W-1:0]   rd_ptr;
  logic [SAMP_W-1:0] samp [N_SAMP];
  logic signed [ACC_W-1:0] res [N_RES];

  wire acc_wr   = psel & penable & pwrite;
  wire wr_cmd   = acc_wr && (paddr == CMD_ADDR);
  wire wr_data  = acc_wr && (paddr == DATA_ADDR);
  wire do_clear = wr_cmd && (pwdata[1:0] == OP_CLEAR);
  wire do_start = wr_cmd && (pwdata[1:0] == OP_START) && !busy && (wcount == CNT_W'(N_SAMP));
  wire do_next  = wr_cmd && (pwdata[1:0] == OP_NEXT);
  wire load_ok  = wr_data && !busy && (wcount < CNT_W'(N_SAMP));

  logic unused_bits;
  assign unused_bits = ^pwdata[DATA_W-1:SAMP_W];

  function automatic logic signed [COEF_W-1:0] quarter(input logic [3:0] a);
    case (a)
      4'd0:    quarter = COEF_W'(0);
      4'd1:    quarter = COEF_W'(12785);
      4'd2:    quarter = COEF_W'(25080);
      4'd3:    quarter = COEF_W'(36410);
      4'd4:    quarter = COEF_W'(46341);
      4'd5:    quarter = COEF_W'(54491);
      4'd6:    quarter = COEF_W'(60547);
      4'd7:    quarter = COEF_W'(64277);
      default: quarter = COEF_W'(65536);
    endcase
  endfunction

  function automatic logic signed [COEF_W-1:0] sin_q(input logic [PH_W-1:0] m);
    logic [3:0] r;
    logic signed [COEF_W-1:0] v;
    r = m[3:0];
    v = (r <= 4'd8) ? quarter(r) : quarter(4'd0 - r);
    sin_q = m[4] ? -v : v;
  endfunction

  function automatic logic signed [ACC_W-1:0] sext_coef(input logic signed [COEF_W-1:0] c);
    sext_coef = {{(ACC_W-COEF_W){c[COEF_W-1]}}, c};
  endfunction

  wire [SAMP_W-1:0]        cur    = samp[idx];
  wire signed [ACC_W-1:0]  cur_ext = {{(ACC_W-SAMP_W){1'b0}}, cur};

  always_ff @(posedge clk) begin
    if (load_ok) samp[wcount[IDX_W-1:0]] <= pwdata[SAMP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      err    <= 1'b0;
      wcount <= '0;
      idx    <= '0;
      rd_ptr <= '0;
    end else if (do_clear) begin
      busy   <= 1'b0;
      err    <= 1'b0;
      wcount <= '0;
      idx    <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_start) begin
        busy   <= 1'b1;
        idx    <= '0;
        wcount <= '0;
        rd_ptr <= '0;
      end else if (busy) begin
        idx <= idx + 1'b1;
        if (idx == IDX_W'(N_SAMP - 1)) busy <= 1'b0;
      end
      if (wr_data && busy) err <= 1'b1;
      if (load_ok) wcount <= wcount + 1'b1;
      if (do_next) rd_ptr <= (rd_ptr == RP_W'(N_RES - 1)) ? '0 : rd_ptr + 1'b1;
    end
  end

  for (genvar g = 0; g < N_LANE; g++) begin : g_lane
    logic [PH_W-1:0]          ph;
    logic signed [ACC_W-1:0]  s_acc, c_acc;
    wire signed [ACC_W-1:0]   s_prod = cur_ext * sext_coef(sin_q(ph));
    wire signed [ACC_W-1:0]   c_prod = cur_ext * sext_coef(sin_q(ph + PH_W'(8)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ph    <= '0;
        s_acc <= '0;
        c_acc <= '0;
      end else if (do_clear || do_start) begin
        ph    <= '0;
        s_acc <= '0;
        c_acc <= '0;
      end else if (busy) begin
        ph    <= ph + PH_W'(g + 1);
        s_acc <= s_acc + s_prod;
        c_acc <= c_acc + c_prod;
      end
    end

    assign res[2*g]     = s_acc;
    assign res[2*g + 1] = c_acc;
  end

  logic [ACC_W-1:0] sel_res;
  assign sel_res = res[rd_ptr];

  always_comb begin
    prdata = '0;
    if (paddr == CMD_ADDR) begin
      prdata[0]            = busy;
      prdata[1]            = err;
      prdata[8 +: CNT_W]   = wcount;
      prdata[16 +: RP_W]   = rd_ptr;
    end else if (paddr == DATA_ADDR) begin
      prdata = sel_res[ACC_W-1 -: DATA_W];
    end
  end

endmodule

// File: rtl/dft_corr_engine_sva.sv
module dft_corr_engine_sva #(
  parameter int N_SAMP = 24,
  parameter int CNT_W  = 5,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 4'h0,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 4'h4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic              busy,
  input logic              err,
  input logic [CNT_W-1:0]  wcount
);

  localparam int RL_W = $clog2(N_SAMP + 2) + 1;

  wire bus_wr = psel && penable && pwrite;
  wire clr_w  = bus_wr && (paddr == CMD_ADDR) && (pwdata[1:0] == 2'd1);
  wire st_w   = bus_wr && (paddr == CMD_ADDR) && (pwdata[1:0] == 2'd2);
  wire dat_w  = bus_wr && (paddr == DATA_ADDR);

  logic [RL_W-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  AST_RUN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(clr_w) |-> run_len == RL_W'(N_SAMP)); // R3
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    st_w && !busy && wcount == CNT_W'(N_SAMP) |=> busy && wcount == '0); // R3
  AST_SHORT_START: assert property (@(posedge clk) disable iff (!rst_n)
    st_w && !busy && wcount != CNT_W'(N_SAMP) |=> !busy); // R4
  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    wcount <= CNT_W'(N_SAMP)); // R2
  AST_BUSY_WR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    busy && dat_w |=> err); // R7
  AST_BUSY_WR_NOLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && dat_w |=> $stable(wcount)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err && !clr_w |=> err); // R7

endmodule

bind dft_corr_engine dft_corr_engine_sva #(
  .N_SAMP(N_SAMP), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .CMD_ADDR(CMD_ADDR), .DATA_ADDR(DATA_ADDR)
) u_sva (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .busy(busy), .err(err), .wcount(wcount)
);

// File: tb/dft_corr_engine_tb.sv
module dft_corr_engine_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [3:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;

  always #5 clk = ~clk;

  dft_corr_engine u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata)
  );

  localparam logic [3:0] A_CMD = 4'h0, A_DAT = 4'h4;

  int n_tests = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       req_q[$];
  logic [31:0] obs_q[$];
  event        obs_ev;
  int          vec[24];
  logic [31:0] refres[8];

  task automatic expect_val(input logic [31:0] v, input string r);
    exp_q.push_back(v);
    req_q.push_back(r);
  endtask

  initial forever begin
    @(obs_ev);
    while (obs_q.size() > 0) begin
      logic [31:0] got;
      got = obs_q.pop_front();
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read: got %h expected none", got);
      end else begin
        logic [31:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if (got !== e) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", r, got, e);
        end
      end
    end
  end

  task automatic apb_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic check_rd(input logic [3:0] a, input logic [31:0] e, input string r);
    expect_val(e, r);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1;
    #1 obs_q.push_back(prdata);
    -> obs_ev;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  function automatic longint coef(input int m, input bit is_cos);
    real ang, s;
    ang = 3.14159265358979323846 * real'(m) / 16.0;
    s = (is_cos ? $cos(ang) : $sin(ang)) * 65536.0;
    return (s >= 0.0) ? longint'($rtoi(s + 0.5)) : -longint'($rtoi(-s + 0.5));
  endfunction

  task automatic build_ref();
    for (int k = 1; k <= 4; k++) begin
      longint s_acc, c_acc;
      s_acc = 0; c_acc = 0;
      for (int i = 0; i < 24; i++) begin
        s_acc += longint'(vec[i]) * coef((k * i) % 32, 1'b0);
        c_acc += longint'(vec[i]) * coef((k * i) % 32, 1'b1);
      end
      refres[2*(k-1)]   = 32'(s_acc >>> 8);
      refres[2*(k-1)+1] = 32'(c_acc >>> 8);
    end
  endtask

  task automatic load_vec();
    for (int i = 0; i < 24; i++) apb_wr(A_DAT, 32'(vec[i]));
  endtask

  task automatic read_all(input string r);
    for (int j = 0; j < 8; j++) begin
      check_rd(A_DAT, refres[j], r);
      apb_wr(A_CMD, 32'd3);
    end
  endtask

  task automatic finish_run();
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL scoreboard: got %0d leftover expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_rd(A_CMD, 32'h0, "R1 status after reset");
    check_rd(A_DAT, 32'h0, "R1 data after reset");

    // ramp vector with a 25th write that must be dropped
    for (int i = 0; i < 24; i++) vec[i] = i * 1000 + 7;
    build_ref();
    load_vec();
    check_rd(A_CMD, 32'h1800, "R2 count 24");
    apb_wr(A_DAT, 32'd50000);
    check_rd(A_CMD, 32'h1800, "R2 count saturates");
    apb_wr(A_CMD, 32'd2);
    check_rd(A_CMD, 32'h1, "R3 busy after start");
    repeat (30) @(negedge clk);
    check_rd(A_CMD, 32'h0, "R3 idle, count and pointer cleared");
    read_all("R5 R6 ramp");
    check_rd(A_CMD, 32'h0, "R6 pointer wraps");
    check_rd(A_DAT, refres[0], "R6 wrap returns sin1");

    // full scale
    for (int i = 0; i < 24; i++) vec[i] = 65535;
    build_ref();
    load_vec();
    apb_wr(A_CMD, 32'd2);
    repeat (30) @(negedge clk);
    read_all("R5 R8 full scale");

    // alternating
    for (int i = 0; i < 24; i++) vec[i] = (i % 2) ? 0 : 65535;
    build_ref();
    load_vec();
    apb_wr(A_CMD, 32'd2);
    repeat (30) @(negedge clk);
    read_all("R5 R8 alternating");

    // single impulse
    for (int i = 0; i < 24; i++) vec[i] = (i == 5) ? 40000 : 0;
    build_ref();
    load_vec();
    apb_wr(A_CMD, 32'd2);
    repeat (30) @(negedge clk);
    read_all("R5 impulse");

    // short vector start is ignored
    apb_wr(A_CMD, 32'd1);
    for (int i = 0; i < 10; i++) apb_wr(A_DAT, 32'd9);
    apb_wr(A_CMD, 32'd2);
    check_rd(A_CMD, 32'h0A00, "R4 short start ignored");
    apb_wr(A_CMD, 32'd1);

    // write during run
    for (int i = 0; i < 24; i++) vec[i] = (i * 7919) % 65536;
    build_ref();
    load_vec();
    apb_wr(A_CMD, 32'd2);
    apb_wr(A_DAT, 32'd1234);
    check_rd(A_CMD, 32'h3, "R7 write while busy ignored, error set");
    repeat (30) @(negedge clk);
    check_rd(A_CMD, 32'h2, "R7 error sticky");
    check_rd(A_DAT, refres[0], "R7 results untouched");
    apb_wr(A_CMD, 32'd3);
    apb_wr(A_CMD, 32'd3);
    check_rd(A_CMD, 32'h20002, "R6 pointer at 2");
    check_rd(A_DAT, refres[2], "R6 sin2 at pointer 2");
    apb_wr(A_CMD, 32'd1);
    check_rd(A_CMD, 32'h0, "R7 clear resets status");
    check_rd(A_DAT, 32'h0, "R7 clear zeroes sums");

    finish_run();
  end
endmodule